// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers interrupt causes from sixteen peripheral sources into one 16-bit flag register. Each source also has an enable bit and a 3-bit priority level. A flag is latched whether or not its source is enabled. Sources 15 to 8 always act on pulses. Each of sources 7 to 0 can instead be put in level mode by a per-source configuration input.

Software sees the flags, enables and levels through a small synchronous register port. A write of 1 to a pulse-mode flag bit clears that flag. Among the pending, enabled sources the block picks a winner: the highest level wins, and on equal levels the lower index wins. It offers that winner to the CPU as a registered request carrying the source index and level. The request is raised only when the CPU's global interrupt enable is set and the winner's level is strictly above the CPU's current interrupt level.

The CPU accepts a request by dropping its own enable. No new request appears until the CPU sets that enable again. The serviced flag must also be cleared, or the same source is offered again.

Top module: `irq_flag_arbiter`

## Requirements
- R1: After reset every flag, every enable bit and every level field is 0, and `irq_req` is 0.
- R2: A pulse-mode source sets its flag on a 0-to-1 transition of its cause input. The flag is readable one cycle after the edge, and it is set whatever the enable and level settings are. A cause held high sets the flag only once, so after a software clear the flag stays 0 while the input stays high.
- R3: A write to address 0 clears every pulse-mode flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged.
- R4: A level-mode source's flag equals its cause input as sampled at the previous clock edge. A write of 1 to that flag has no effect.
- R5: When a pulse edge and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R6: A source whose enable bit is 0 never produces a request.
- R7: No request is raised while `cpu_ie` is 0.
- R8: A request is raised only when the winner's level is strictly greater than `cpu_il`. A source with level 0 never produces a request.
- R9: Among pending enabled sources, the highest level wins. Equal levels go to the lower source index. `irq_vec` carries the index and `irq_lvl` carries the level.
- R10: The request is registered. It appears two cycles after a cause edge is applied and falls one cycle after the flag clears or eligibility is lost.
- R11: Register map:
  - Address 0 reads the flags, with bit i for source i.
  - Address 1 is the enable register, read/write, with bit i for source i.
  - Addresses 2 to 5 each hold four level fields. Source 4k+j uses bits [4j+2:4j] of address 2+k, and bit 4j+3 reads 0.
  - All other addresses read 0.
- R12: Sources 15 to 8 behave as pulse-mode sources even when their level-mode configuration bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cause_in | input | 16 | Interrupt cause lines, one per source |
| trig_level | input | 16 | Per-source level-mode select (1 = level) |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_il | input | 3 | CPU current interrupt level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 4 | Index of the requesting source |
| irq_lvl | output | 3 | Level of the requesting source |

## Verification
A cause edge, a flag write or a level-mode input change is visible in the flags one cycle after the inputs are applied. The request output follows one cycle after that, so it lags any flag change by exactly one cycle. A change on `cpu_ie` or `cpu_il` moves the request one cycle after it is applied. The driver tags each expected value with the cycle it is due in, counted from the edge the stimulus is applied at. The monitor samples on the falling clock edge and compares only items whose due cycle has arrived. That includes the cycle where a request is still high just after its flag has been cleared.

// File: rtl/irq_flag_arbiter.sv
module irq_flag_arbiter #(
  parameter int NSRC = 16,
  parameter int LVLW = 3,
  parameter int AW = 3,
  parameter logic [NSRC-1:0] PULSE_ONLY = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  input  logic [NSRC-1:0]   cause_in,
  input  logic [NSRC-1:0]   trig_level,
  input  logic              cpu_ie,
  input  logic [LVLW-1:0]   cpu_il,
  output logic              irq_req,
  output logic [$clog2(NSRC)-1:0] irq_vec,
  output logic [LVLW-1:0]   irq_lvl
);

  localparam int IW = $clog2(NSRC);
  localparam int PITCH = 4;
  localparam int PER_REG = NSRC / PITCH;
  localparam int NLREG = NSRC / PER_REG;
  localparam int LBASE = 2;

  logic [NSRC-1:0] flag_r, en_r, cause_q;
  logic [LVLW-1:0] lvl_r [NSRC];

  wire wr_flag = reg_wr && (reg_addr == AW'(0));
  wire wr_en   = reg_wr && (reg_addr == AW'(1));

  wire [NSRC-1:0] lvl_mode = trig_level & ~PULSE_ONLY;
  wire [NSRC-1:0] rise     = cause_in & ~cause_q & ~lvl_mode;
  wire [NSRC-1:0] clr      = wr_flag ? reg_wdata : '0;
  wire [NSRC-1:0] flag_nxt = (lvl_mode & cause_in) |
                             (~lvl_mode & ((flag_r & ~clr) | rise));
  wire [NSRC-1:0] elig     = flag_r & en_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r  <= '0;
      cause_q <= '0;
      en_r    <= '0;
    end else begin
      flag_r  <= flag_nxt;
      cause_q <= cause_in;
      if (wr_en) en_r <= reg_wdata;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    localparam int RI = g / PER_REG;
    localparam int FI = g % PER_REG;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_r[g] <= '0;
      else if (reg_wr && reg_addr == AW'(LBASE + RI))
        lvl_r[g] <= reg_wdata[FI*PITCH +: LVLW];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0)) reg_rdata = flag_r;
    else if (reg_addr == AW'(1)) reg_rdata = en_r;
    else
      for (int k = 0; k < NLREG; k++)
        if (reg_addr == AW'(LBASE + k))
          for (int j = 0; j < PER_REG; j++)
            reg_rdata[j*PITCH +: LVLW] = lvl_r[k*PER_REG + j];
  end

  logic            found;
  logic [LVLW-1:0] best_lvl;
  logic [IW-1:0]   best_idx;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i] && (!found || lvl_r[i] >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_r[i];
        best_idx = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end else begin
      irq_req <= found && cpu_ie && (best_lvl > cpu_il);
      irq_vec <= best_idx;
      irq_lvl <= best_lvl;
    end
  end

  a_r2_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((flag_r & $past(rise)) == $past(rise)));

  a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_r & $past(lvl_mode)) == ($past(cause_in) & $past(lvl_mode))));

  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((($past(elig) >> irq_vec) & NSRC'(1)) != '0));

  a_r7_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(cpu_ie));

  a_r8_above_cpu_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > $past(cpu_il)));

  a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && reg_wdata == '0 && lvl_mode == '0) |=> ((flag_r & $past(flag_r)) == $past(flag_r)));

endmodule

// File: tb/tb_irq_flag_arbiter.sv
module tb_irq_flag_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] cause = '0;
  logic [15:0] trig_level = 16'h1010;
  logic        cpu_ie = 1'b1;
  logic [2:0]  cpu_il = '0;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic [2:0]  irq_lvl;

  irq_flag_arbiter dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cause_in(cause),
    .trig_level(trig_level), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    bit          crd;
    logic [15:0] rd;
    bit          cirq;
    logic        rq;
    logic [3:0]  vec;
    logic [2:0]  lvl;
    string       rid;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        mismatched++;
        $display("FAIL %s: item due cycle %0d missed (now %0d)", e.rid, e.due, cyc);
        continue;
      end
      if (e.crd) begin
        compared++;
        if (reg_rdata !== e.rd) begin
          mismatched++;
          $display("FAIL %s: rdata actual %h expected %h (cycle %0d)", e.rid, reg_rdata, e.rd, cyc);
        end
      end
      if (e.cirq) begin
        compared++;
        if (irq_req !== e.rq || (e.rq && (irq_vec !== e.vec || irq_lvl !== e.lvl))) begin
          mismatched++;
          $display("FAIL %s: req/vec/lvl actual %b/%0d/%0d expected %b/%0d/%0d (cycle %0d)",
                   e.rid, irq_req, irq_vec, irq_lvl, e.rq, e.vec, e.lvl, cyc);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic exp_rd(int off, logic [15:0] v, string rid);
    exp_t e;
    e = '{due: cyc + off, crd: 1'b1, rd: v, cirq: 1'b0, rq: 1'b0, vec: '0, lvl: '0, rid: rid};
    q.push_back(e);
  endtask

  task automatic exp_irq(int off, logic rq, logic [3:0] v, logic [2:0] l, string rid);
    exp_t e;
    e = '{due: cyc + off, crd: 1'b0, rd: '0, cirq: 1'b1, rq: rq, vec: v, lvl: l, rid: rid};
    q.push_back(e);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [15:0] v, string rid);
    reg_addr = a;
    exp_rd(1, v, rid);
    tick(); tick();
    reg_addr = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    exp_rd(1, 16'h0000, "R1");
    exp_irq(1, 1'b0, 0, 0, "R1");
    tick(); tick();
    rd_chk(3'd1, 16'h0000, "R1");
    rd_chk(3'd2, 16'h0000, "R1");

    wr(3'd2, 16'hFFFF);
    rd_chk(3'd2, 16'h7777, "R11");
    rd_chk(3'd6, 16'h0000, "R11");
    wr(3'd2, 16'h2551);
    rd_chk(3'd2, 16'h2551, "R11");
    wr(3'd3, 16'h0003);
    wr(3'd4, 16'h0060);
    wr(3'd5, 16'h0004);
    wr(3'd1, 16'hA5C3);
    rd_chk(3'd1, 16'hA5C3, "R11");
    wr(3'd1, 16'h0000);

    cause[1] = 1'b1;
    exp_rd(1, 16'h0002, "R2");
    exp_irq(1, 1'b0, 0, 0, "R6");
    exp_irq(2, 1'b0, 0, 0, "R6");
    tick();
    wr(3'd0, 16'h0000);
    exp_rd(1, 16'h0002, "R3");
    tick();
    wr(3'd0, 16'h0002);
    exp_rd(1, 16'h0000, "R3");
    tick(); tick();
    exp_rd(1, 16'h0000, "R2");
    tick();
    cause[1] = 1'b0;
    tick();

    wr(3'd1, 16'h0002);
    cause[1] = 1'b1;
    exp_rd(1, 16'h0002, "R10");
    exp_irq(1, 1'b0, 0, 0, "R10");
    exp_irq(2, 1'b1, 4'd1, 3'd5, "R10");
    tick();
    cause[1] = 1'b0;
    tick();
    exp_irq(1, 1'b1, 4'd1, 3'd5, "R10");
    exp_irq(2, 1'b0, 0, 0, "R10");
    wr(3'd0, 16'h0002);
    exp_rd(1, 16'h0000, "R3");
    tick(); tick();

    cause[0] = 1'b1;
    tick();
    cause[0] = 1'b0;
    tick();
    cause[0] = 1'b1;
    reg_addr = '0; reg_wdata = 16'h0001; reg_wr = 1'b1;
    exp_rd(1, 16'h0001, "R5");
    tick();
    reg_wr = 1'b0; reg_wdata = '0; cause[0] = 1'b0;
    tick();
    wr(3'd0, 16'h0001);
    exp_rd(1, 16'h0000, "R3");
    tick(); tick();

    cause[4] = 1'b1;
    exp_rd(1, 16'h0010, "R4");
    tick();
    wr(3'd0, 16'h0010);
    exp_rd(1, 16'h0010, "R4");
    tick();
    cause[4] = 1'b0;
    exp_rd(1, 16'h0000, "R4");
    tick(); tick();

    cause[12] = 1'b1;
    exp_rd(1, 16'h1000, "R12");
    tick(); tick();
    wr(3'd0, 16'h1000);
    exp_rd(1, 16'h0000, "R12");
    tick(); tick();
    exp_rd(1, 16'h0000, "R12");
    tick();
    cause[12] = 1'b0;
    tick();

    wr(3'd1, 16'h020F);
    cause = 16'h0009;
    exp_rd(1, 16'h0009, "R9");
    exp_irq(2, 1'b1, 4'd3, 3'd2, "R9");
    tick();
    cause = '0;
    tick();
    cpu_il = 3'd2;
    exp_irq(1, 1'b0, 0, 0, "R8");
    tick();
    cpu_il = 3'd1;
    exp_irq(1, 1'b1, 4'd3, 3'd2, "R8");
    tick();
    cause = 16'h0006;
    exp_irq(1, 1'b1, 4'd3, 3'd2, "R9");
    exp_rd(1, 16'h000F, "R9");
    exp_irq(2, 1'b1, 4'd1, 3'd5, "R9");
    tick();
    cause = '0;
    tick(); tick();
    cause = 16'h0200;
    exp_irq(2, 1'b1, 4'd9, 3'd6, "R9");
    tick();
    cause = '0;
    tick(); tick();
    cpu_ie = 1'b0;
    exp_irq(1, 1'b0, 0, 0, "R7");
    tick(); tick();
    cpu_ie = 1'b1;
    exp_irq(1, 1'b1, 4'd9, 3'd6, "R7");
    tick(); tick();
    exp_irq(1, 1'b1, 4'd9, 3'd6, "R10");
    exp_irq(2, 1'b1, 4'd1, 3'd5, "R10");
    wr(3'd0, 16'h0200);
    tick(); tick();
    wr(3'd0, 16'hFFFF);
    exp_rd(1, 16'h0000, "R3");
    exp_irq(1, 1'b0, 0, 0, "R10");
    tick(); tick();

    cpu_il = 3'd0;
    wr(3'd1, 16'h0020);
    cause = 16'h0020;
    exp_rd(1, 16'h0020, "R8");
    exp_irq(2, 1'b0, 0, 0, "R8");
    tick();
    cause = '0;
    tick(); tick();
    wr(3'd0, 16'h0020);
    exp_rd(1, 16'h0000, "R3");
    tick(); tick(); tick();

    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R10: %0d expected items never compared", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1: watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule